// File: doc/BRIEF.md
# Scoreboard Hazard Controller

This block is the central hazard tracker for a small out-of-order core. The core has six execution slots: two integer units, two floating-point adders, one multiplier and one divider. Each cycle the controller decides whether the next decoded instruction may enter a slot, which slots may fetch their operands, and which finished slot may write its result. The arithmetic, the register file, instruction fetch and branching are outside the block. The controller only sees a decoded instruction, which is an opcode, a destination, two sources and a unit class. It also sees one completion pulse per slot.

The controller keeps a status record for every slot and a table that names the pending producer of each register. Together these let it catch structural conflicts, true dependences, anti-dependences and output dependences. An instruction that is refused stays at the head of the front end, so every instruction behind it waits as well. The status records and the producer table are brought out so that the rest of the core and the bench can observe them.

Top module: `sb_ctrl`

## Requirements
- R1: After reset every slot is idle, every producer-table entry is 0 (no producer), and no issue, read or write-back grant is raised.
- R2: Unit classes are coded 0 integer, 1 FP add, 2 FP multiply, 3 FP divide. Slot IDs are 1-2 integer, 3-4 adder, 5 multiplier and 6 divider. An instruction is accepted only if a slot of its class is idle, and the lowest-numbered idle slot of that class takes it. That slot records the opcode.
- R3: An instruction whose destination already has a producer in the table is refused in that cycle. This is the output-dependence check.
- R4: When an instruction is accepted, the table entry for its destination holds the slot ID from the next cycle on.
- R5: At issue, each source takes its producer from the table. A source is marked ready with producer 0 when it has no producer, or when its producer is writing back in the same cycle.
- R6: A slot gets a read grant in any cycle in which it holds an instruction whose two sources are both ready and have not yet been read. After the read, both ready flags are cleared. One instruction gets exactly one read grant.
- R7: A completion pulse counts only for a slot that has read its operands and has not already completed. The slot then requests write-back. Any other pulse is ignored.
- R8: A slot that has completed is held back from write-back while any other busy slot still has an unread, ready source that names its destination. This is the anti-dependence check.
- R9: On write-back, every slot waiting on the writer gets that source marked ready with producer 0. The writer's table entry becomes 0 and the writer slot becomes idle.
- R10: At most one write-back is granted per cycle. Among the eligible slots, the one with the lowest ID wins.
- R11: A refused instruction leaves every status record and the producer table unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iss_valid | input | 1 | A decoded instruction is presented |
| iss_cls | input | 2 | Unit class of the instruction |
| iss_op | input | OP_W | Opcode stored in the slot |
| iss_dst | input | REG_W | Destination register |
| iss_src1 | input | REG_W | First source register |
| iss_src2 | input | REG_W | Second source register |
| done_i | input | NFU | Per-slot completion pulse |
| iss_ready | output | 1 | Instruction accepted this cycle |
| iss_unit | output | FU_W | Slot ID taking the instruction (0 if none) |
| rd_grant_o | output | NFU | Per-slot operand-read grant |
| wb_grant_o | output | NFU | Per-slot write-back grant |
| fu_busy_o | output | NFU | Per-slot busy flag |
| fu_rj_o | output | NFU | First-source ready flags |
| fu_rk_o | output | NFU | Second-source ready flags |
| fu_qj_o | output | NFU*FU_W | First-source producer IDs |
| fu_qk_o | output | NFU*FU_W | Second-source producer IDs |
| fu_op_o | output | NFU*OP_W | Stored opcodes |
| reg_prod_o | output | 2**REG_W*FU_W | Producer table, entry r at bits r*FU_W |

## Verification
The bench drives a divide that waits on a multiply result while an add overwrites the divide's other source. A design without the anti-dependence check would let the add write back early and corrupt the value the divide has not yet read. It also completes three slots in the same cycle. Wrong priority or a double grant shows up as a misordered or multi-hot write-back. In that same sequence, an instruction is issued whose source producer is writing back in the same cycle. A design without the bypass would leave that source waiting on a slot that has already been freed, and it would never become ready. Further cases cover refused instructions hitting a full class or an already-claimed destination, and stray completion pulses on slots that have not read their operands. Random traffic is then compared cycle by cycle with a bench model of all the tables.

// File: rtl/sb_pkg.sv
package sb_pkg;

   typedef enum logic [1:0] {
      CLS_INT  = 2'd0,
      CLS_FADD = 2'd1,
      CLS_FMUL = 2'd2,
      CLS_FDIV = 2'd3
   } unit_cls_e;

   // Slots are laid out class by class: integer, adder, multiplier, divider.
   function automatic unit_cls_e cls_of_slot(input int slot, input int n_int,
                                             input int n_add, input int n_mul);
      if (slot < n_int)                    return CLS_INT;
      else if (slot < n_int + n_add)       return CLS_FADD;
      else if (slot < n_int + n_add + n_mul) return CLS_FMUL;
      else                                 return CLS_FDIV;
   endfunction

endpackage

// File: rtl/sb_unit_alloc.sv
module sb_unit_alloc
   import sb_pkg::*;
#(
   parameter int NFU   = 6,
   parameter int FU_W  = 3,
   parameter int N_INT = 2,
   parameter int N_ADD = 2,
   parameter int N_MUL = 1
)(
   input  logic [NFU-1:0]  busy,
   input  logic [1:0]      want_cls,
   output logic            found,
   output logic [NFU-1:0]  pick,
   output logic [FU_W-1:0] pick_id
);

   logic [NFU-1:0] cls_hit;

   for (genvar g = 0; g < NFU; g++) begin : g_slot
      localparam unit_cls_e SLOT_CLS = cls_of_slot(g, N_INT, N_ADD, N_MUL);
      assign cls_hit[g] = !busy[g] && (want_cls == SLOT_CLS);
   end

   always_comb begin
      found   = 1'b0;
      pick    = '0;
      pick_id = '0;
      for (int u = 0; u < NFU; u++) begin
         if (cls_hit[u] && !found) begin
            found   = 1'b1;
            pick[u] = 1'b1;
            pick_id = FU_W'(u + 1);
         end
      end
   end

endmodule

// File: rtl/sb_wb_arbiter.sv
module sb_wb_arbiter #(
   parameter int NFU   = 6,
   parameter int REG_W = 3,
   parameter int FU_W  = 3
)(
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [NFU-1:0]             busy,
   input  logic [NFU-1:0]             wb_req,
   input  logic [NFU-1:0][REG_W-1:0]  fi,
   input  logic [NFU-1:0][REG_W-1:0]  fj,
   input  logic [NFU-1:0][REG_W-1:0]  fk,
   input  logic [NFU-1:0]             rj,
   input  logic [NFU-1:0]             rk,
   output logic [NFU-1:0]             gnt,
   output logic                       any,
   output logic [FU_W-1:0]            id
);

   logic [NFU-1:0] war_hold;
   logic [NFU-1:0] elig;

   // Anti-dependence: another slot still owes a read of this slot's target.
   for (genvar f = 0; f < NFU; f++) begin : g_war
      always_comb begin
         war_hold[f] = 1'b0;
         for (int o = 0; o < NFU; o++) begin
            if (o != f && busy[o] &&
                ((fj[o] == fi[f] && rj[o]) || (fk[o] == fi[f] && rk[o])))
               war_hold[f] = 1'b1;
         end
      end
   end

   assign elig = wb_req & ~war_hold;

   always_comb begin
      gnt = '0;
      any = 1'b0;
      id  = '0;
      for (int u = 0; u < NFU; u++) begin
         if (elig[u] && !any) begin
            any    = 1'b1;
            gnt[u] = 1'b1;
            id     = FU_W'(u + 1);
         end
      end
   end

   // R10
   single_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt));

endmodule

// File: rtl/sb_unit_entry.sv
module sb_unit_entry #(
   parameter int              REG_W   = 3,
   parameter int              FU_W    = 3,
   parameter int              OP_W    = 4,
   parameter logic [FU_W-1:0] SELF_ID = 1
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [OP_W-1:0]  ld_op,
   input  logic [REG_W-1:0] ld_fi,
   input  logic [REG_W-1:0] ld_fj,
   input  logic [REG_W-1:0] ld_fk,
   input  logic [FU_W-1:0]  ld_qj,
   input  logic [FU_W-1:0]  ld_qk,
   input  logic             ld_rj,
   input  logic             ld_rk,
   input  logic             rd_gnt,
   input  logic             wb_gnt,
   input  logic             done_pulse,
   input  logic [FU_W-1:0]  bcast_id,
   output logic             busy,
   output logic [OP_W-1:0]  op,
   output logic [REG_W-1:0] fi,
   output logic [REG_W-1:0] fj,
   output logic [REG_W-1:0] fk,
   output logic [FU_W-1:0]  qj,
   output logic [FU_W-1:0]  qk,
   output logic             rj,
   output logic             rk,
   output logic             rd_req,
   output logic             wb_req
);

   logic read_q;
   logic fin_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         op     <= '0;
         fi     <= '0;
         fj     <= '0;
         fk     <= '0;
         qj     <= '0;
         qk     <= '0;
         rj     <= 1'b0;
         rk     <= 1'b0;
         read_q <= 1'b0;
         fin_q  <= 1'b0;
      end else if (wb_gnt) begin
         busy   <= 1'b0;
         op     <= '0;
         fi     <= '0;
         fj     <= '0;
         fk     <= '0;
         qj     <= '0;
         qk     <= '0;
         rj     <= 1'b0;
         rk     <= 1'b0;
         read_q <= 1'b0;
         fin_q  <= 1'b0;
      end else if (load) begin
         busy   <= 1'b1;
         op     <= ld_op;
         fi     <= ld_fi;
         fj     <= ld_fj;
         fk     <= ld_fk;
         qj     <= ld_qj;
         qk     <= ld_qk;
         rj     <= ld_rj;
         rk     <= ld_rk;
         read_q <= 1'b0;
         fin_q  <= 1'b0;
      end else begin
         if (rd_gnt) begin
            rj     <= 1'b0;
            rk     <= 1'b0;
            read_q <= 1'b1;
         end else begin
            if (bcast_id != '0 && qj == bcast_id) begin
               qj <= '0;
               rj <= 1'b1;
            end
            if (bcast_id != '0 && qk == bcast_id) begin
               qk <= '0;
               rk <= 1'b1;
            end
         end
         if (done_pulse && busy && read_q && !fin_q)
            fin_q <= 1'b1;
      end
   end

   assign rd_req = busy && rj && rk && !read_q;
   assign wb_req = busy && fin_q;

   // R6
   read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_gnt |=> (!rj && !rk && read_q));

   // R9
   free_on_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wb_gnt |=> !busy);

   // R7
   wb_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wb_req |-> read_q);

   // R5
   no_self_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (qj != SELF_ID && qk != SELF_ID));

endmodule

// File: rtl/sb_ctrl.sv
module sb_ctrl
   import sb_pkg::*;
#(
   parameter int REG_W = 3,
   parameter int FU_W  = 3,
   parameter int OP_W  = 4,
   parameter int N_INT = 2,
   parameter int N_ADD = 2,
   parameter int N_MUL = 1,
   parameter int N_DIV = 1,
   localparam int NFU  = N_INT + N_ADD + N_MUL + N_DIV,
   localparam int NREG = 1 << REG_W
)(
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   iss_valid,
   input  logic [1:0]             iss_cls,
   input  logic [OP_W-1:0]        iss_op,
   input  logic [REG_W-1:0]       iss_dst,
   input  logic [REG_W-1:0]       iss_src1,
   input  logic [REG_W-1:0]       iss_src2,
   input  logic [NFU-1:0]         done_i,
   output logic                   iss_ready,
   output logic [FU_W-1:0]        iss_unit,
   output logic [NFU-1:0]         rd_grant_o,
   output logic [NFU-1:0]         wb_grant_o,
   output logic [NFU-1:0]         fu_busy_o,
   output logic [NFU-1:0]         fu_rj_o,
   output logic [NFU-1:0]         fu_rk_o,
   output logic [NFU*FU_W-1:0]    fu_qj_o,
   output logic [NFU*FU_W-1:0]    fu_qk_o,
   output logic [NFU*OP_W-1:0]    fu_op_o,
   output logic [NREG*FU_W-1:0]   reg_prod_o
);

   if (N_INT < 1 || N_ADD < 1 || N_MUL < 1 || N_DIV < 1) begin : g_bad_mix
      $error("each unit class needs at least one slot");
   end
   if (NFU > (1 << FU_W) - 1) begin : g_bad_idw
      $error("FU_W too narrow for slot IDs with 0 reserved");
   end
   if (REG_W < 1) begin : g_bad_regw
      $error("REG_W must be positive");
   end

   logic [NREG-1:0][FU_W-1:0]  prod;
   logic [NFU-1:0]             busy_a, rj_a, rk_a, rd_req_a, wb_req_a;
   logic [NFU-1:0][REG_W-1:0]  fi_a, fj_a, fk_a;
   logic [NFU-1:0][FU_W-1:0]   qj_a, qk_a;
   logic [NFU-1:0][OP_W-1:0]   op_a;
   logic [NFU-1:0]             pick;
   logic                       found;
   logic [FU_W-1:0]            pick_id;
   logic [NFU-1:0]             wb_gnt;
   logic                       wb_any;
   logic [FU_W-1:0]            wb_id;
   logic [FU_W-1:0]            src_q1, src_q2;

   sb_unit_alloc #(
      .NFU(NFU), .FU_W(FU_W), .N_INT(N_INT), .N_ADD(N_ADD), .N_MUL(N_MUL)
   ) u_alloc (
      .busy(busy_a), .want_cls(iss_cls), .found(found), .pick(pick), .pick_id(pick_id)
   );

   sb_wb_arbiter #(.NFU(NFU), .REG_W(REG_W), .FU_W(FU_W)) u_wb_arb (
      .clk(clk), .rst_n(rst_n), .busy(busy_a), .wb_req(wb_req_a),
      .fi(fi_a), .fj(fj_a), .fk(fk_a), .rj(rj_a), .rk(rk_a),
      .gnt(wb_gnt), .any(wb_any), .id(wb_id)
   );

   assign iss_ready = iss_valid && found && (prod[iss_dst] == '0);
   assign iss_unit  = iss_ready ? pick_id : '0;

   // Producer lookup; a producer retiring this very cycle counts as done.
   always_comb begin
      src_q1 = prod[iss_src1];
      src_q2 = prod[iss_src2];
      if (wb_any && src_q1 == wb_id) src_q1 = '0;
      if (wb_any && src_q2 == wb_id) src_q2 = '0;
   end

   for (genvar g = 0; g < NFU; g++) begin : g_unit
      sb_unit_entry #(
         .REG_W(REG_W), .FU_W(FU_W), .OP_W(OP_W), .SELF_ID(FU_W'(g + 1))
      ) u_entry (
         .clk(clk), .rst_n(rst_n),
         .load(iss_ready && pick[g]),
         .ld_op(iss_op), .ld_fi(iss_dst), .ld_fj(iss_src1), .ld_fk(iss_src2),
         .ld_qj(src_q1), .ld_qk(src_q2),
         .ld_rj(src_q1 == '0), .ld_rk(src_q2 == '0),
         .rd_gnt(rd_req_a[g]), .wb_gnt(wb_gnt[g]), .done_pulse(done_i[g]),
         .bcast_id(wb_id),
         .busy(busy_a[g]), .op(op_a[g]), .fi(fi_a[g]), .fj(fj_a[g]), .fk(fk_a[g]),
         .qj(qj_a[g]), .qk(qk_a[g]), .rj(rj_a[g]), .rk(rk_a[g]),
         .rd_req(rd_req_a[g]), .wb_req(wb_req_a[g])
      );
      assign fu_qj_o[g*FU_W +: FU_W] = qj_a[g];
      assign fu_qk_o[g*FU_W +: FU_W] = qk_a[g];
      assign fu_op_o[g*OP_W +: OP_W] = op_a[g];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prod <= '0;
      end else begin
         for (int r = 0; r < NREG; r++) begin
            if (iss_ready && iss_dst == REG_W'(r))
               prod[r] <= pick_id;
            else if (wb_any && prod[r] == wb_id)
               prod[r] <= '0;
         end
      end
   end

   for (genvar r = 0; r < NREG; r++) begin : g_prod_out
      assign reg_prod_o[r*FU_W +: FU_W] = prod[r];
   end

   assign rd_grant_o = rd_req_a;
   assign wb_grant_o = wb_gnt;
   assign fu_busy_o  = busy_a;
   assign fu_rj_o    = rj_a;
   assign fu_rk_o    = rk_a;

   // R4
   dst_claimed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      iss_ready |=> prod[$past(iss_dst)] == $past(iss_unit));

   // R2
   slot_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
      iss_ready |=> (busy_a & $past(pick)) == $past(pick));

   // R6
   read_wb_apart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_grant_o & wb_grant_o) == '0);

endmodule

// File: tb/sb_ctrl_tb_top.sv
`timescale 1ns/1ps
module sb_ctrl_tb_top;
   localparam int NFU = 6, NR = 8, RW = 3, FW = 3, OW = 4;

   logic clk = 1'b0, rst_n = 1'b0;
   always #10 clk = ~clk;

   logic iss_valid; logic [1:0] iss_cls; logic [OW-1:0] iss_op;
   logic [RW-1:0] iss_dst, iss_src1, iss_src2; logic [NFU-1:0] done_i;
   logic iss_ready; logic [FW-1:0] iss_unit;
   logic [NFU-1:0] rd_grant_o, wb_grant_o, fu_busy_o, fu_rj_o, fu_rk_o;
   logic [NFU*FW-1:0] fu_qj_o, fu_qk_o; logic [NFU*OW-1:0] fu_op_o;
   logic [NR*FW-1:0] reg_prod_o;

   sb_ctrl dut_i (.*);

   int checks = 0, errors = 0; bit finished = 0;
   bit mb[NFU], mrj[NFU], mrk[NFU], mrd[NFU], mdn[NFU];
   int mfi[NFU], mfj[NFU], mfk[NFU], mqj[NFU], mqk[NFU], mop[NFU], mprod[NR];
   bit p_acc; int p_unit; logic [NFU-1:0] p_rd, p_wb;
   bit last_acc; logic [NFU-1:0] last_wb;

   function automatic int cls_of(int u);
      return (u < 2) ? 0 : (u < 4) ? 1 : (u == 4) ? 2 : 3;
   endfunction

   task automatic chk(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
      end
   endtask

   task automatic compare_state();
      for (int u = 0; u < NFU; u++) begin
         chk("R9 busy", fu_busy_o[u], mb[u]);
         chk("R5 R6 ready j", fu_rj_o[u], mrj[u]);
         chk("R5 R6 ready k", fu_rk_o[u], mrk[u]);
         chk("R5 producer j", fu_qj_o[u*FW +: FW], mqj[u]);
         chk("R5 producer k", fu_qk_o[u*FW +: FW], mqk[u]);
         chk("R2 opcode", fu_op_o[u*OW +: OW], mop[u]);
      end
      for (int r = 0; r < NR; r++)
         chk("R4 R11 producer table", reg_prod_o[r*FW +: FW], mprod[r]);
   endtask

   task automatic predict(bit v, int cls, int d);
      bit war;
      p_unit = 0;
      if (v) for (int u = 0; u < NFU; u++)
         if (!mb[u] && cls_of(u) == cls && p_unit == 0) p_unit = u + 1;
      p_acc = v && p_unit != 0 && mprod[d] == 0;
      p_wb = '0;
      for (int u = 0; u < NFU; u++) p_rd[u] = mb[u] && mrj[u] && mrk[u] && !mrd[u];
      for (int f = 0; f < NFU; f++) begin
         war = 0;
         for (int o = 0; o < NFU; o++)
            if (o != f && mb[o] && ((mfj[o] == mfi[f] && mrj[o]) || (mfk[o] == mfi[f] && mrk[o])))
               war = 1;
         if (mb[f] && mdn[f] && !war && p_wb == '0) p_wb[f] = 1'b1;
      end
   endtask

   task automatic update(int op, int d, int s1, int s2, logic [NFU-1:0] dn);
      int w = 0, iu = p_acc ? p_unit : 0;
      for (int f = 0; f < NFU; f++) if (p_wb[f]) w = f + 1;
      for (int u = 0; u < NFU; u++) begin
         if (p_wb[u]) begin
            mb[u]=0; mrj[u]=0; mrk[u]=0; mrd[u]=0; mdn[u]=0;
            mfi[u]=0; mfj[u]=0; mfk[u]=0; mqj[u]=0; mqk[u]=0; mop[u]=0;
         end else if (iu == u + 1) begin
            mb[u]=1; mop[u]=op; mfi[u]=d; mfj[u]=s1; mfk[u]=s2; mrd[u]=0; mdn[u]=0;
            mqj[u] = (mprod[s1] != 0 && mprod[s1] != w) ? mprod[s1] : 0;
            mqk[u] = (mprod[s2] != 0 && mprod[s2] != w) ? mprod[s2] : 0;
            mrj[u] = (mqj[u] == 0); mrk[u] = (mqk[u] == 0);
         end else begin
            bit oldrd = mrd[u];
            if (p_rd[u]) begin mrj[u]=0; mrk[u]=0; mrd[u]=1; end
            else begin
               if (w != 0 && mqj[u] == w) begin mqj[u]=0; mrj[u]=1; end
               if (w != 0 && mqk[u] == w) begin mqk[u]=0; mrk[u]=1; end
            end
            if (dn[u] && mb[u] && oldrd && !mdn[u]) mdn[u] = 1;
         end
      end
      for (int r = 0; r < NR; r++) begin
         if (iu != 0 && d == r) mprod[r] = iu;
         else if (w != 0 && mprod[r] == w) mprod[r] = 0;
      end
   endtask

   task automatic step(bit v, int cls, int op, int d, int s1, int s2, logic [NFU-1:0] dn);
      @(negedge clk);
      compare_state();
      iss_valid = v; iss_cls = cls[1:0]; iss_op = op[OW-1:0];
      iss_dst = d[RW-1:0]; iss_src1 = s1[RW-1:0]; iss_src2 = s2[RW-1:0]; done_i = dn;
      #1;
      predict(v, cls, d);
      chk("R2 R3 issue accept", iss_ready, p_acc);
      if (p_acc) chk("R2 slot choice", iss_unit, p_unit);
      chk("R6 read grant", rd_grant_o, p_rd);
      chk("R7 R8 R10 write-back grant", wb_grant_o, p_wb);
      last_acc = iss_ready; last_wb = wb_grant_o;
      update(op, d, s1, s2, dn);
   endtask

   function automatic logic [NFU-1:0] ready_done();
      logic [NFU-1:0] m = '0;
      for (int u = 0; u < NFU; u++) m[u] = mb[u] && mrd[u] && !mdn[u];
      return m;
   endfunction

   task automatic drain();
      for (int i = 0; i < 60; i++) step(0, 0, 0, 0, 0, 0, ready_done());
   endtask

   task automatic summary();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL R1 watchdog act=running exp=finished");
         summary();
         $finish;
      end
   end

   initial begin
      bit have; int pc, po, pd, p1, p2; logic [NFU-1:0] dn;
      void'($urandom(32'd2718));
      iss_valid = 0; iss_cls = 0; iss_op = 0; iss_dst = 0; iss_src1 = 0; iss_src2 = 0; done_i = 0;
      foreach (mb[u]) begin mb[u]=0; mrj[u]=0; mrk[u]=0; mrd[u]=0; mdn[u]=0;
         mfi[u]=0; mfj[u]=0; mfk[u]=0; mqj[u]=0; mqk[u]=0; mop[u]=0; end
      foreach (mprod[r]) mprod[r] = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1 reset state
      chk("R1 busy after reset", fu_busy_o, 0);
      chk("R1 table after reset", reg_prod_o, 0);
      chk("R1 no read grant", rd_grant_o, 0);
      chk("R1 no write-back grant", wb_grant_o, 0);
      chk("R1 no accept", iss_ready, 0);
      rst_n = 1;

      // R2 full integer class refuses a third integer op
      step(1, 0, 1, 1, 0, 0, 0); chk("R2 first int accepted", last_acc, 1);
      step(1, 0, 2, 2, 0, 0, 0); chk("R2 second int accepted", last_acc, 1);
      step(1, 0, 3, 3, 0, 0, 0); chk("R2 third int refused", last_acc, 0);
      drain();

      // R3 destination already claimed
      step(1, 0, 4, 3, 0, 0, 0); chk("R3 producer claims F3", last_acc, 1);
      step(1, 1, 5, 3, 1, 1, 0); chk("R3 second writer of F3 refused", last_acc, 0);
      begin
         bit got = 0;
         for (int i = 0; i < 12 && !got; i++) begin
            step(1, 1, 5, 3, 1, 1, ready_done());
            got = last_acc;
         end
         chk("R3 R9 writer enters after retire", got, 1);
      end
      drain();

      // R8 anti-dependence: divide reads F6 late, add overwrites F6
      step(1, 2, 6, 0, 2, 4, 0);          // mul F0, slot 5
      step(1, 3, 7, 7, 0, 6, 0);          // div F7 <- F0,F6 waits on slot 5
      step(1, 1, 8, 6, 5, 2, 0);          // add F6, slot 3
      step(0, 0, 0, 0, 0, 0, 0);          // add reads
      step(0, 0, 0, 0, 0, 0, 6'b000100);  // add completes
      step(0, 0, 0, 0, 0, 0, 0);
      chk("R8 add held by unread F6", last_wb, 0);
      step(0, 0, 0, 0, 0, 0, 6'b010000);  // mul completes
      step(0, 0, 0, 0, 0, 0, 0);
      chk("R9 mul writes back", last_wb, 6'b010000);
      step(0, 0, 0, 0, 0, 0, 0);          // div reads
      chk("R8 still held during read cycle", last_wb, 0);
      step(0, 0, 0, 0, 0, 0, 0);
      chk("R8 add released after read", last_wb, 6'b000100);
      drain();

      // R10 priority and R5 same-cycle bypass
      step(1, 1, 1, 1, 3, 3, 0);          // add F1, slot 3
      step(1, 1, 2, 2, 3, 3, 0);          // add F2, slot 4
      step(1, 0, 3, 4, 3, 3, 0);          // int F4, slot 1
      step(0, 0, 0, 0, 0, 0, 0);
      step(0, 0, 0, 0, 0, 0, 6'b001101);
      step(0, 0, 0, 0, 0, 0, 0);
      chk("R10 lowest ID first", last_wb, 6'b000001);
      step(1, 2, 9, 5, 1, 2, 0);          // mul F5 <- F1,F2 while slot 3 retires
      chk("R10 second in order", last_wb, 6'b000100);
      @(posedge clk); #1;
      chk("R5 bypass marks source ready", fu_rj_o[4], 1);
      chk("R5 bypass leaves no producer", fu_qj_o[4*FW +: FW], 0);
      chk("R5 other source waits", fu_qk_o[4*FW +: FW], 4);
      step(0, 0, 0, 0, 0, 0, 0);
      chk("R10 third in order", last_wb, 6'b001000);
      drain();

      // Random traffic; R7 stray pulses included
      have = 0; pc = 0; po = 0; pd = 0; p1 = 0; p2 = 0;
      for (int n = 0; n < 3000; n++) begin
         bit v;
         if (!have) begin
            pc = $urandom % 4; po = $urandom % 16; pd = $urandom % 8;
            p1 = $urandom % 8; p2 = $urandom % 8; have = 1;
         end
         v = ($urandom % 4) != 0;
         dn = '0;
         for (int u = 0; u < NFU; u++)
            if ((mb[u] && mrd[u] && !mdn[u] && ($urandom % 3 == 0)) || ($urandom % 10 == 0))
               dn[u] = 1'b1;
         step(v, pc, po, pd, p1, p2, dn);
         if (v && last_acc) have = 0;
      end
      drain();
      @(negedge clk);
      compare_state();
      finished = 1;
      summary();
      $finish;
   end
endmodule